// File: doc/BRIEF.md
# Crypto Bit-Manipulation Execute Unit

This block executes the bit-manipulation operations that scalar cryptography code relies on. It takes a 32-bit instruction word and two source operands, works out which operation the word encodes and computes the result. The operations are half-word packing, byte packing, bit interleave and de-interleave, bit reversal inside each byte, byte reversal, rotates by register or by immediate (including the 32-bit word forms), and the inverted-operand logic operations. The datapath width `XLEN` is a parameter and may be 32 or 64. Which encodings are legal depends on that width.

The decode and datapath are combinational. A single register stage sits behind them. An instruction presented with `in_valid` high gives its result, together with an illegal flag, exactly one clock later with `out_valid` high. Any word that is not a legal encoding for the configured width sets the flag and yields a zero result. Register-file access, writeback and pipeline control belong to the surrounding core.

Top module: `cbx_unit`

## Requirements
- R1: A register-form word with opcode 0110011, bits[31:25]=0000100 and bits[14:12]=100 returns {rs2[XLEN/2-1:0], rs1[XLEN/2-1:0]}.
- R2: The same opcode and bits[31:25] with bits[14:12]=111 returns {rs2[7:0], rs1[7:0]}, zero-extended to XLEN.
- R3: When XLEN is 64, opcode 0111011 with bits[31:25]=0000100 and bits[14:12]=100 returns {rs2[15:0], rs1[15:0]}, zero-extended. When XLEN is 32 this word is illegal.
- R4: When XLEN is 32, opcode 0010011 with bits[31:20]=000010001111 interleaves or de-interleaves. With bits[14:12]=001, result bit 2i is rs1[i] and result bit 2i+1 is rs1[i+16]. With bits[14:12]=101, result bits 15:0 are the even source bits and bits 31:16 are the odd source bits. When XLEN is 64, both words are illegal.
- R5: Opcode 0010011 with bits[14:12]=101 and bits[31:20]=011010000111 reverses the bit order inside every byte of rs1 and keeps the byte order.
- R6: Opcode 0010011 with bits[14:12]=101 reverses the byte order of rs1. The immediate bits[31:20] must be 011010011000 when XLEN is 32 and 011010111000 when XLEN is 64. The immediate of the other width is illegal.
- R7: Opcode 0110011 with bits[31:25]=0110000 rotates rs1 by rs2 modulo XLEN: right for bits[14:12]=101, left for 001. Opcode 0010011 with bits[14:12]=101 and bits[31:26]=011000 rotates right by bits[25:20]. When XLEN is 32 and bit 25 is set, that word is illegal.
- R8: When XLEN is 64, the word rotates act on rs1[31:0] and sign-extend the 32-bit result. Opcode 0111011 with bits[31:25]=0110000 rotates by rs2[4:0] (right for bits[14:12]=101, left for 001). Opcode 0011011 with bits[31:25]=0110000 and bits[14:12]=101 rotates right by bits[24:20]. When XLEN is 32, every word on these two opcodes is illegal.
- R9: Opcode 0110011 with bits[31:25]=0100000 returns rs1 & ~rs2 for bits[14:12]=111, rs1 | ~rs2 for 110, and ~(rs1 ^ rs2) for 100.
- R10: A word matching no legal encoding for the configured XLEN sets `out_illegal` and gives `out_result` of zero. A legal word clears `out_illegal`.
- R11: `out_valid` is `in_valid` delayed by one clock. While `in_valid` is low, `out_result` and `out_illegal` keep their values.
- R12: While `rst` is high, `out_valid`, `out_result` and `out_illegal` are cleared on every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands present |
| in_instr | input | 32 | Instruction word |
| in_rs1 | input | XLEN | First source operand |
| in_rs2 | input | XLEN | Second source operand |
| out_valid | output | 1 | Result present, one clock after the input |
| out_result | output | XLEN | Result, zero when illegal |
| out_illegal | output | 1 | Instruction word not legal for this XLEN |

## Verification
Each result and illegal flag is due on the first rising edge after the cycle in which `in_valid` was high, and not before. The bench drives inputs on the falling edge and reads the outputs shortly after the next rising edge. At that point it compares them with the value its behavioural reference model computed for the inputs it has just applied. In idle cycles the expected values are carried over unchanged, so the hold behaviour is checked on every clock. A 64-bit and a 32-bit instance receive the same stimulus, so each legality rule that depends on the width is seen from both sides.

// File: rtl/cbx_pkg.sv
package cbx_pkg;

  typedef enum logic [4:0] {
    OP_NONE, OP_PACK, OP_PACKH, OP_PACKW, OP_ZIP, OP_UNZIP,
    OP_BREV8, OP_REV8, OP_ROR, OP_ROL, OP_RORI,
    OP_RORW, OP_ROLW, OP_RORIW, OP_ANDN, OP_ORN, OP_XNOR
  } cbx_op_e;

  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_REG_W = 7'b0111011;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_IMM_W = 7'b0011011;

  localparam logic [6:0] F7_PACK = 7'b0000100;
  localparam logic [6:0] F7_LOGN = 7'b0100000;
  localparam logic [6:0] F7_ROT  = 7'b0110000;

  localparam logic [5:0]  IMM_RORI_HI = 6'b011000;
  localparam logic [11:0] IMM_BREV8   = 12'b011010000111;
  localparam logic [11:0] IMM_REV8_32 = 12'b011010011000;
  localparam logic [11:0] IMM_REV8_64 = 12'b011010111000;
  localparam logic [11:0] IMM_ZIP     = 12'b000010001111;

endpackage

// File: rtl/cbx_decode.sv
module cbx_decode
  import cbx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [11:0] fld_hi,
  input  logic [2:0]  fld_f3,
  input  logic [6:0]  fld_opc,
  output cbx_op_e     op,
  output logic        illegal
);
  localparam bit IS64 = (XLEN == 64);
  localparam logic [11:0] REV8_IMM = IS64 ? IMM_REV8_64 : IMM_REV8_32;

  logic [6:0] f7;
  assign f7 = fld_hi[11:5];

  always_comb begin
    op = OP_NONE;
    case (fld_opc)
      OPC_REG: begin
        if (f7 == F7_PACK && fld_f3 == 3'b100)      op = OP_PACK;
        else if (f7 == F7_PACK && fld_f3 == 3'b111) op = OP_PACKH;
        else if (f7 == F7_LOGN && fld_f3 == 3'b111) op = OP_ANDN;
        else if (f7 == F7_LOGN && fld_f3 == 3'b110) op = OP_ORN;
        else if (f7 == F7_LOGN && fld_f3 == 3'b100) op = OP_XNOR;
        else if (f7 == F7_ROT  && fld_f3 == 3'b101) op = OP_ROR;
        else if (f7 == F7_ROT  && fld_f3 == 3'b001) op = OP_ROL;
      end
      OPC_REG_W: begin
        if (IS64) begin
          if (f7 == F7_PACK && fld_f3 == 3'b100)      op = OP_PACKW;
          else if (f7 == F7_ROT && fld_f3 == 3'b101)  op = OP_RORW;
          else if (f7 == F7_ROT && fld_f3 == 3'b001)  op = OP_ROLW;
        end
      end
      OPC_IMM: begin
        if (fld_f3 == 3'b101) begin
          if (fld_hi[11:6] == IMM_RORI_HI && (IS64 || !fld_hi[5])) op = OP_RORI;
          else if (fld_hi == IMM_BREV8)                           op = OP_BREV8;
          else if (fld_hi == REV8_IMM)                            op = OP_REV8;
          else if (!IS64 && fld_hi == IMM_ZIP)                    op = OP_UNZIP;
        end else if (fld_f3 == 3'b001 && !IS64 && fld_hi == IMM_ZIP) begin
          op = OP_ZIP;
        end
      end
      OPC_IMM_W: begin
        if (IS64 && fld_f3 == 3'b101 && f7 == F7_ROT) op = OP_RORIW;
      end
      default: op = OP_NONE;
    endcase
    illegal = (op == OP_NONE);
  end

endmodule

// File: rtl/cbx_rotr.sv
module cbx_rotr #(
  parameter int W  = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [2*W-1:0] dbl;
  assign dbl  = {din, din} >> amt;
  assign dout = dbl[W-1:0];
endmodule

// File: rtl/cbx_datapath.sv
module cbx_datapath
  import cbx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  cbx_op_e         op,
  input  logic [5:0]      shamt,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res
);
  localparam int HALF  = XLEN / 2;
  localparam int SHW   = $clog2(XLEN);
  localparam int NBYTE = XLEN / 8;

  logic [XLEN-1:0] v_pack, v_packh, v_packw, v_zip, v_unzip;
  logic [XLEN-1:0] v_brev, v_rev, v_rot, v_wrot;
  logic [SHW-1:0]  full_amt;
  logic [4:0]      word_amt;
  logic [31:0]     word_rot;

  assign v_pack  = {b[HALF-1:0], a[HALF-1:0]};
  assign v_packh = {{(XLEN-16){1'b0}}, b[7:0], a[7:0]};

  // interleave / de-interleave across the two halves
  for (genvar i = 0; i < HALF; i++) begin : g_zip
    assign v_zip[2*i]      = a[i];
    assign v_zip[2*i+1]    = a[i+HALF];
    assign v_unzip[i]      = a[2*i];
    assign v_unzip[i+HALF] = a[2*i+1];
  end

  // per-byte bit reversal and whole-word byte reversal
  for (genvar k = 0; k < NBYTE; k++) begin : g_byte
    for (genvar j = 0; j < 8; j++) begin : g_bit
      assign v_brev[8*k+j] = a[8*k+7-j];
    end
    assign v_rev[8*k +: 8] = a[8*(NBYTE-1-k) +: 8];
  end

  always_comb begin
    case (op)
      OP_ROL:  full_amt = -b[SHW-1:0];
      OP_RORI: full_amt = shamt[SHW-1:0];
      default: full_amt = b[SHW-1:0];
    endcase
    case (op)
      OP_ROLW:  word_amt = -b[4:0];
      OP_RORIW: word_amt = shamt[4:0];
      default:  word_amt = b[4:0];
    endcase
  end

  cbx_rotr #(.W(XLEN)) u_rot_full (.din(a), .amt(full_amt), .dout(v_rot));
  cbx_rotr #(.W(32))   u_rot_word (.din(a[31:0]), .amt(word_amt), .dout(word_rot));

  if (XLEN > 32) begin : g_wide
    assign v_wrot  = {{(XLEN-32){word_rot[31]}}, word_rot};
    assign v_packw = {{(XLEN-32){1'b0}}, b[15:0], a[15:0]};
  end else begin : g_narrow
    assign v_wrot  = word_rot;
    assign v_packw = {b[15:0], a[15:0]};
  end

  always_comb begin
    case (op)
      OP_PACK:  res = v_pack;
      OP_PACKH: res = v_packh;
      OP_PACKW: res = v_packw;
      OP_ZIP:   res = v_zip;
      OP_UNZIP: res = v_unzip;
      OP_BREV8: res = v_brev;
      OP_REV8:  res = v_rev;
      OP_ROR, OP_ROL, OP_RORI:    res = v_rot;
      OP_RORW, OP_ROLW, OP_RORIW: res = v_wrot;
      OP_ANDN:  res = a & ~b;
      OP_ORN:   res = a | ~b;
      OP_XNOR:  res = ~(a ^ b);
      default:  res = '0;
    endcase
  end

endmodule

// File: rtl/cbx_unit.sv
module cbx_unit
  import cbx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     in_instr,
  input  logic [XLEN-1:0] in_rs1,
  input  logic [XLEN-1:0] in_rs2,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result,
  output logic            out_illegal
);
  cbx_op_e         dec_op;
  logic            dec_illegal;
  logic [XLEN-1:0] dp_res;
  logic            unused_fields;

  assign unused_fields = ^{in_instr[19:15], in_instr[11:7]};

  cbx_decode #(.XLEN(XLEN)) u_decode (
    .fld_hi  (in_instr[31:20]),
    .fld_f3  (in_instr[14:12]),
    .fld_opc (in_instr[6:0]),
    .op      (dec_op),
    .illegal (dec_illegal)
  );

  cbx_datapath #(.XLEN(XLEN)) u_datapath (
    .op    (dec_op),
    .shamt (in_instr[25:20]),
    .a     (in_rs1),
    .b     (in_rs2),
    .res   (dp_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= dp_res;
        out_illegal <= dec_illegal;
      end
    end
  end

  // R12: reset clears the output stage
  assert_reset_clear_R12: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0 && !out_illegal));

  // R11: one-cycle latency and hold while idle
  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_drops_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_result) && $stable(out_illegal)));

  // R10: illegal words give zero
  assert_illegal_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> out_result == '0);
  assert_bad_opcode_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_instr[6:0] != OPC_REG && in_instr[6:0] != OPC_REG_W &&
     in_instr[6:0] != OPC_IMM && in_instr[6:0] != OPC_IMM_W) |=> out_illegal);

  // R8: word forms rejected at 32 bits
  assert_wordform_xlen_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && XLEN == 32 &&
     (in_instr[6:0] == OPC_REG_W || in_instr[6:0] == OPC_IMM_W)) |=> out_illegal);

  // R2: byte pack leaves the upper bits clear
  assert_packh_upper_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_instr[6:0] == OPC_REG && in_instr[31:25] == F7_PACK &&
     in_instr[14:12] == 3'b111) |=> (!out_illegal && out_result[XLEN-1:16] == '0));

endmodule

// File: tb/cbx_unit_tb.sv
module cbx_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;

  logic        v64, il64, v32, il32;
  logic [63:0] r64;
  logic [31:0] r32;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        exp_v = 1'b0;
  logic [63:0] exp_r64 = '0, exp_r32 = '0;
  logic        exp_i64 = 1'b0, exp_i32 = 1'b0;

  always #4 clk = ~clk;

  cbx_unit #(.XLEN(64)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
    .in_rs1(in_a), .in_rs2(in_b),
    .out_valid(v64), .out_result(r64), .out_illegal(il64));

  cbx_unit #(.XLEN(32)) u_dut32 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
    .in_rs1(in_a[31:0]), .in_rs2(in_b[31:0]),
    .out_valid(v32), .out_result(r32), .out_illegal(il32));

  function automatic logic [31:0] rtype(logic [6:0] f7, logic [2:0] f3, logic [6:0] opc);
    return {f7, 5'd3, 5'd2, f3, 5'd1, opc};
  endfunction

  function automatic logic [31:0] itype(logic [11:0] imm, logic [2:0] f3, logic [6:0] opc);
    return {imm, 5'd2, f3, 5'd1, opc};
  endfunction

  // behavioural reference of the requirements
  function automatic logic [63:0] ref_op(input int xl, input logic [31:0] ins,
                                         input logic [63:0] ai, input logic [63:0] bi,
                                         output bit ill);
    logic [63:0] a, b, r, m, lo;
    logic [31:0] w;
    logic [6:0] opc, f7;
    logic [2:0] f3;
    logic [11:0] im;
    int s, h;
    opc = ins[6:0]; f7 = ins[31:25]; f3 = ins[14:12]; im = ins[31:20];
    m = (xl == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    a = ai & m; b = bi & m; r = '0; w = '0; ill = 0; h = xl / 2;
    lo = (64'd1 << h) - 64'd1;
    if (opc == 7'b0110011 && f7 == 7'b0000100 && f3 == 3'b100)
      r = ((b & lo) << h) | (a & lo);
    else if (opc == 7'b0110011 && f7 == 7'b0000100 && f3 == 3'b111)
      r = {48'd0, b[7:0], a[7:0]};
    else if (opc == 7'b0110011 && f7 == 7'b0100000 && f3 == 3'b111) r = a & ~b;
    else if (opc == 7'b0110011 && f7 == 7'b0100000 && f3 == 3'b110) r = a | ~b;
    else if (opc == 7'b0110011 && f7 == 7'b0100000 && f3 == 3'b100) r = ~(a ^ b);
    else if (opc == 7'b0110011 && f7 == 7'b0110000 && (f3 == 3'b101 || f3 == 3'b001)) begin
      s = int'(b[5:0]) % xl;
      for (int i = 0; i < xl; i++)
        if (f3 == 3'b101) r[i] = a[(i + s) % xl];
        else              r[(i + s) % xl] = a[i];
    end
    else if (xl == 64 && opc == 7'b0111011 && f7 == 7'b0000100 && f3 == 3'b100)
      r = {32'd0, b[15:0], a[15:0]};
    else if (xl == 64 && ((opc == 7'b0111011 && f7 == 7'b0110000 && (f3 == 3'b101 || f3 == 3'b001)) ||
                          (opc == 7'b0011011 && f7 == 7'b0110000 && f3 == 3'b101))) begin
      s = (opc == 7'b0011011) ? int'(ins[24:20]) : int'(b[4:0]);
      for (int i = 0; i < 32; i++)
        if (f3 == 3'b101) w[i] = a[(i + s) % 32];
        else              w[(i + s) % 32] = a[i];
      r = {{32{w[31]}}, w};
    end
    else if (opc == 7'b0010011 && f3 == 3'b101 && im[11:6] == 6'b011000 && (xl == 64 || !im[5])) begin
      s = int'(im[5:0]);
      for (int i = 0; i < xl; i++) r[i] = a[(i + s) % xl];
    end
    else if (opc == 7'b0010011 && f3 == 3'b101 && im == 12'b011010000111) begin
      for (int i = 0; i < xl; i++) r[i] = a[(i / 8) * 8 + 7 - (i % 8)];
    end
    else if (opc == 7'b0010011 && f3 == 3'b101 &&
             im == ((xl == 64) ? 12'b011010111000 : 12'b011010011000)) begin
      for (int k = 0; k < xl / 8; k++) r[8*k +: 8] = a[8*(xl/8 - 1 - k) +: 8];
    end
    else if (xl == 32 && opc == 7'b0010011 && im == 12'b000010001111 && f3 == 3'b001) begin
      for (int i = 0; i < 16; i++) begin r[2*i] = a[i]; r[2*i+1] = a[i+16]; end
    end
    else if (xl == 32 && opc == 7'b0010011 && im == 12'b000010001111 && f3 == 3'b101) begin
      for (int i = 0; i < 16; i++) begin r[i] = a[2*i]; r[i+16] = a[2*i+1]; end
    end
    else ill = 1;
    return r & m;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(v64 === exp_v, "R11", "valid64", 64'(v64), 64'(exp_v));
    check(v32 === exp_v, "R11", "valid32", 64'(v32), 64'(exp_v));
    check(r64 === exp_r64, tag, "result64", r64, exp_r64);
    check(il64 === exp_i64, tag, "illegal64", 64'(il64), 64'(exp_i64));
    check(r32 === exp_r32[31:0], tag, "result32", 64'(r32), exp_r32);
    check(il32 === exp_i32, tag, "illegal32", 64'(il32), 64'(exp_i32));
  endtask

  task automatic step(input bit vld, input logic [31:0] ins,
                      input logic [63:0] a, input logic [63:0] b, input string tag);
    bit i64, i32;
    logic [63:0] e64, e32;
    @(negedge clk);
    in_valid = vld; in_instr = ins; in_a = a; in_b = b;
    if (vld) begin
      e64 = ref_op(64, ins, a, b, i64);
      e32 = ref_op(32, ins, a, b, i32);
      exp_r64 = e64; exp_i64 = i64; exp_r32 = e32; exp_i32 = i32;
    end
    exp_v = vld;
    @(posedge clk);
    #2;
    compare_all(vld ? tag : "R11");
  endtask

  task automatic reset_check();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_instr = rtype(7'b0000100, 3'b100, 7'b0110011);
    in_a = 64'h1234_5678_9ABC_DEF0; in_b = 64'h0FED_CBA9_8765_4321;
    repeat (2) @(posedge clk);
    #2;
    exp_v = 1'b0; exp_r64 = '0; exp_r32 = '0; exp_i64 = 1'b0; exp_i32 = 1'b0;
    compare_all("R12");
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  localparam int NI = 24;
  logic [31:0] ilist [NI];
  string       tlist [NI];
  logic [63:0] pa [6];
  logic [63:0] pb [6];
  logic [63:0] seed;

  initial begin
    ilist[0]  = rtype(7'b0000100, 3'b100, 7'b0110011); tlist[0]  = "R1";
    ilist[1]  = rtype(7'b0000100, 3'b111, 7'b0110011); tlist[1]  = "R2";
    ilist[2]  = rtype(7'b0000100, 3'b100, 7'b0111011); tlist[2]  = "R3";
    ilist[3]  = itype(12'b000010001111, 3'b001, 7'b0010011); tlist[3] = "R4";
    ilist[4]  = itype(12'b000010001111, 3'b101, 7'b0010011); tlist[4] = "R4";
    ilist[5]  = itype(12'b011010000111, 3'b101, 7'b0010011); tlist[5] = "R5";
    ilist[6]  = itype(12'b011010011000, 3'b101, 7'b0010011); tlist[6] = "R6";
    ilist[7]  = itype(12'b011010111000, 3'b101, 7'b0010011); tlist[7] = "R6";
    ilist[8]  = rtype(7'b0110000, 3'b101, 7'b0110011); tlist[8]  = "R7";
    ilist[9]  = rtype(7'b0110000, 3'b001, 7'b0110011); tlist[9]  = "R7";
    ilist[10] = itype({6'b011000, 6'd13}, 3'b101, 7'b0010011); tlist[10] = "R7";
    ilist[11] = itype({6'b011000, 6'd45}, 3'b101, 7'b0010011); tlist[11] = "R7";
    ilist[12] = itype({6'b011000, 6'd0}, 3'b101, 7'b0010011);  tlist[12] = "R7";
    ilist[13] = rtype(7'b0110000, 3'b101, 7'b0111011); tlist[13] = "R8";
    ilist[14] = rtype(7'b0110000, 3'b001, 7'b0111011); tlist[14] = "R8";
    ilist[15] = itype({7'b0110000, 5'd7}, 3'b101, 7'b0011011); tlist[15] = "R8";
    ilist[16] = rtype(7'b0100000, 3'b111, 7'b0110011); tlist[16] = "R9";
    ilist[17] = rtype(7'b0100000, 3'b110, 7'b0110011); tlist[17] = "R9";
    ilist[18] = rtype(7'b0100000, 3'b100, 7'b0110011); tlist[18] = "R9";
    ilist[19] = rtype(7'b0000001, 3'b000, 7'b0110011); tlist[19] = "R10";
    ilist[20] = itype(12'hFFF, 3'b101, 7'b0010011);    tlist[20] = "R10";
    ilist[21] = 32'hFFFF_FFFF;                           tlist[21] = "R10";
    ilist[22] = rtype(7'b0000100, 3'b101, 7'b0110011); tlist[22] = "R10";
    ilist[23] = rtype(7'b0110000, 3'b000, 7'b0111011); tlist[23] = "R10";

    pa[0] = 64'h0123_4567_89AB_CDEF; pb[0] = 64'hFEDC_BA98_7654_3210;
    pa[1] = 64'h0;                   pb[1] = 64'h0;
    pa[2] = 64'hFFFF_FFFF_FFFF_FFFF; pb[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    pa[3] = 64'h8000_0000_8000_0001; pb[3] = 64'h0000_0000_0000_0021;
    pa[4] = 64'hA5A5_5A5A_F00F_0FF0; pb[4] = 64'h0000_0000_0000_001F;
    pa[5] = 64'h1357_9BDF_2468_ACE0; pb[5] = 64'h0000_0000_0000_0040;

    reset_check();
    // R12 right after reset: idle outputs stay cleared
    step(1'b0, '0, '0, '0, "R12");

    for (int k = 0; k < NI; k++) begin
      for (int p = 0; p < 6; p++) step(1'b1, ilist[k], pa[p], pb[p], tlist[k]);
      step(1'b0, 32'h0, 64'hDEAD_BEEF_DEAD_BEEF, 64'h1, "R11");
    end

    seed = 64'h9E37_79B9_7F4A_7C15;
    for (int n = 0; n < 400; n++) begin
      logic [63:0] ra, rb;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 7); seed = seed ^ (seed << 17);
      ra = seed;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 7); seed = seed ^ (seed << 17);
      rb = seed;
      step((n % 5) != 4, ilist[n % NI], ra, rb, tlist[n % NI]);
    end

    // R12: reset in the middle of traffic
    reset_check();
    step(1'b1, ilist[0], pa[0], pb[0], "R1");

    finish_run();
  end

endmodule